// File: doc/BRIEF.md
# Console Alarm and Status Flag Bank

This block holds the processor's sticky status flags that drive the console lamps. The flags are operator demand, arithmetic overflow, I/O error, memory parity error, trap mode, test, stall alarm and interrupt-watchdog stall. Each flag is a single register with its own set sources and clear sources. These sources are one-cycle strobes from the instruction decoder, the console push buttons, the hardware error detectors and the initialize pulse. Console switch levels also gate some sources.

Two counters run inside the block. The first is a stall timer, which the stall hold-off instruction restarts. The second is an interrupt watchdog, which a trap return restarts. The length of each counter is a parameter. The console switches enable or lock out each counter. Disabling the whole console overrides the lockout positions, so both counters run while the console is disabled. Every flag changes at the clock edge that samples its source. The flags themselves are the outputs.

Top module: `console_flags`

## Requirements
- R1: While rst_ni is low, every flag output is 0.
- R2: demand_o sets on dmd_release_i. It clears on ins_dmd_ack_i or init_i. The change is seen after the sampling edge.
- R3: overflow_o sets on ovf_evt_i. It clears on ins_ovf_ack_i, on ins_ld_reg_i or on init_i.
- R4: io_err_o sets on io_err_evt_i. It clears on ins_io_ack_i, on init_i, or on alarm_clr_i while console_en_i is 1.
- R5: parity_err_o sets on par_err_evt_i. It clears on ins_par_ack_i, on init_i, or on alarm_clr_i while console_en_i is 1.
- R6: alarm_clr_i has no effect while console_en_i is 0.
- R7: trap_mode_o sets in either of two cases: ins_trap_on_i, or ins_ld_state_i/ins_ld_reg_i with ld_trap_bit_i=1. A load with ld_trap_bit_i=0 leaves the flag unchanged. The flag clears on trap_err_i, or on mprot_lock_sw_i=1 while console_en_i=1. init_i does not change it.
- R8: test_o sets on test_set_i. It clears on test_clr_i or init_i.
- R9: When a set source and a clear source for the same flag arrive in the same cycle, the flag is 1 afterwards.
- R10: The stall timer is enabled when stall_en_sw_i=1 or console_en_i=0. While it is enabled, stall_o rises at the STALL_CYCLES-th clock edge after the last ins_stall_hold_i or init_i, provided no further restart arrives. Only init_i clears stall_o.
- R11: With console_en_i=1 and stall_en_sw_i=0, the stall timer is stopped. stall_o does not rise, and the count restarts from zero.
- R12: The interrupt watchdog is enabled when irq_lock_sw_i=0 or console_en_i=0. While it is enabled, irq_stall_o rises at the WDOG_CYCLES-th edge after the last ins_trap_ret_i or init_i. irq_stall_o clears on ins_trap_ret_i or init_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Initialize strobe |
| console_en_i | input | 1 | Console key switch, 1 = enabled |
| dmd_release_i | input | 1 | Demand button release strobe |
| alarm_clr_i | input | 1 | Alarm-clear button strobe |
| stall_en_sw_i | input | 1 | Stall timer switch, 1 = enable position |
| irq_lock_sw_i | input | 1 | Interrupt switch, 1 = lockout position |
| mprot_lock_sw_i | input | 1 | Memory-protect switch, 1 = lockout position |
| ovf_evt_i | input | 1 | Arithmetic overflow strobe |
| io_err_evt_i | input | 1 | I/O parity or timing error strobe |
| par_err_evt_i | input | 1 | Memory parity error strobe |
| trap_err_i | input | 1 | Trap error strobe |
| test_set_i | input | 1 | Instruction strobe that sets test |
| test_clr_i | input | 1 | Instruction strobe that clears test |
| ins_dmd_ack_i | input | 1 | Demand-test instruction strobe |
| ins_ovf_ack_i | input | 1 | Overflow-test instruction strobe |
| ins_io_ack_i | input | 1 | I/O-error-test instruction strobe |
| ins_par_ack_i | input | 1 | Parity-test instruction strobe |
| ins_trap_on_i | input | 1 | Set-trap-mode instruction strobe |
| ins_ld_state_i | input | 1 | Load-state instruction strobe |
| ins_ld_reg_i | input | 1 | Load-program-register instruction strobe |
| ld_trap_bit_i | input | 1 | Trap-mode bit of the loaded word |
| ins_stall_hold_i | input | 1 | Stall hold-off instruction strobe |
| ins_trap_ret_i | input | 1 | Trap-caused return strobe |
| demand_o | output | 1 | Demand flag |
| overflow_o | output | 1 | Overflow flag |
| io_err_o | output | 1 | I/O error flag |
| parity_err_o | output | 1 | Memory parity flag |
| trap_mode_o | output | 1 | Trap mode flag |
| test_o | output | 1 | Test flag |
| stall_o | output | 1 | Stall alarm flag |
| irq_stall_o | output | 1 | Interrupt watchdog stall flag |

## Verification
Some properties are checked on every cycle. These cover the one-edge response of the flags to their set strobes, clears winning only when no set arrives, the alarm-clear button being ignored while the console is disabled, the stall flag staying set until initialize, and the stall flag staying low while the stall timer is switched off. A trap return always leaves the watchdog flag low, and that too is checked on every cycle. The exact edge on which each timer expires depends on the restart history and on the switch overrides. Only the bench scenarios can show this: they count edges from each restart, restart the stall timer part-way through a count, and let both timers run while the console is disabled.

// File: rtl/console_flags_pkg.sv
package console_flags_pkg;
  typedef enum int unsigned {
    FL_DEMAND   = 0,
    FL_OVF      = 1,
    FL_IOERR    = 2,
    FL_PARITY   = 3,
    FL_TRAP     = 4,
    FL_TEST     = 5,
    FL_STALL    = 6,
    FL_IRQSTALL = 7
  } flag_idx_e;
  localparam int unsigned NumFlags = 8;
endpackage

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;  // set has priority
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/span_timer.sv
module span_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int unsigned CntW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CntW-1:0] LastVal = CntW'(LIMIT - 1);

  logic [CntW-1:0] cnt_q;

  assign expire_o = en_i & ~restart_i & (cnt_q == LastVal);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!en_i || restart_i || expire_o) cnt_q <= '0;
    else cnt_q <= cnt_q + CntW'(1);
  end
endmodule

// File: rtl/flag_src_map.sv
module flag_src_map
  import console_flags_pkg::*;
(
  input  logic                init_i,
  input  logic                console_en_i,
  input  logic                dmd_release_i,
  input  logic                alarm_clr_i,
  input  logic                mprot_lock_sw_i,
  input  logic                ovf_evt_i,
  input  logic                io_err_evt_i,
  input  logic                par_err_evt_i,
  input  logic                trap_err_i,
  input  logic                test_set_i,
  input  logic                test_clr_i,
  input  logic                ins_dmd_ack_i,
  input  logic                ins_ovf_ack_i,
  input  logic                ins_io_ack_i,
  input  logic                ins_par_ack_i,
  input  logic                ins_trap_on_i,
  input  logic                ins_ld_state_i,
  input  logic                ins_ld_reg_i,
  input  logic                ld_trap_bit_i,
  input  logic                ins_trap_ret_i,
  input  logic                stall_exp_i,
  input  logic                wdog_exp_i,
  output logic [NumFlags-1:0] set_o,
  output logic [NumFlags-1:0] clr_o
);
  logic alarm_btn;
  assign alarm_btn = alarm_clr_i & console_en_i;  // button dead with console off

  always_comb begin
    set_o = '0;
    clr_o = '0;
    set_o[FL_DEMAND]   = dmd_release_i;
    clr_o[FL_DEMAND]   = ins_dmd_ack_i | init_i;
    set_o[FL_OVF]      = ovf_evt_i;
    clr_o[FL_OVF]      = ins_ovf_ack_i | ins_ld_reg_i | init_i;
    set_o[FL_IOERR]    = io_err_evt_i;
    clr_o[FL_IOERR]    = ins_io_ack_i | alarm_btn | init_i;
    set_o[FL_PARITY]   = par_err_evt_i;
    clr_o[FL_PARITY]   = ins_par_ack_i | alarm_btn | init_i;
    set_o[FL_TRAP]     = ins_trap_on_i | ((ins_ld_state_i | ins_ld_reg_i) & ld_trap_bit_i);
    clr_o[FL_TRAP]     = trap_err_i | (mprot_lock_sw_i & console_en_i);
    set_o[FL_TEST]     = test_set_i;
    clr_o[FL_TEST]     = test_clr_i | init_i;
    set_o[FL_STALL]    = stall_exp_i;
    clr_o[FL_STALL]    = init_i;
    set_o[FL_IRQSTALL] = wdog_exp_i;
    clr_o[FL_IRQSTALL] = ins_trap_ret_i | init_i;
  end
endmodule

// File: rtl/console_flags.sv
module console_flags
  import console_flags_pkg::*;
#(
  parameter int unsigned STALL_CYCLES = 1000,
  parameter int unsigned WDOG_CYCLES  = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic console_en_i,
  input  logic dmd_release_i,
  input  logic alarm_clr_i,
  input  logic stall_en_sw_i,
  input  logic irq_lock_sw_i,
  input  logic mprot_lock_sw_i,
  input  logic ovf_evt_i,
  input  logic io_err_evt_i,
  input  logic par_err_evt_i,
  input  logic trap_err_i,
  input  logic test_set_i,
  input  logic test_clr_i,
  input  logic ins_dmd_ack_i,
  input  logic ins_ovf_ack_i,
  input  logic ins_io_ack_i,
  input  logic ins_par_ack_i,
  input  logic ins_trap_on_i,
  input  logic ins_ld_state_i,
  input  logic ins_ld_reg_i,
  input  logic ld_trap_bit_i,
  input  logic ins_stall_hold_i,
  input  logic ins_trap_ret_i,
  output logic demand_o,
  output logic overflow_o,
  output logic io_err_o,
  output logic parity_err_o,
  output logic trap_mode_o,
  output logic test_o,
  output logic stall_o,
  output logic irq_stall_o
);
  logic [NumFlags-1:0] set_vec, clr_vec, flag_q;
  logic stall_run, wdog_run, stall_exp, wdog_exp;

  // a disabled console overrides lockout positions
  assign stall_run = stall_en_sw_i | ~console_en_i;
  assign wdog_run  = ~irq_lock_sw_i | ~console_en_i;

  span_timer #(.LIMIT(STALL_CYCLES)) u_stall_tmr (
    .clk_i, .rst_ni, .en_i(stall_run),
    .restart_i(ins_stall_hold_i | init_i), .expire_o(stall_exp)
  );

  span_timer #(.LIMIT(WDOG_CYCLES)) u_wdog_tmr (
    .clk_i, .rst_ni, .en_i(wdog_run),
    .restart_i(ins_trap_ret_i | init_i), .expire_o(wdog_exp)
  );

  flag_src_map u_map (
    .init_i, .console_en_i, .dmd_release_i, .alarm_clr_i, .mprot_lock_sw_i,
    .ovf_evt_i, .io_err_evt_i, .par_err_evt_i, .trap_err_i, .test_set_i,
    .test_clr_i, .ins_dmd_ack_i, .ins_ovf_ack_i, .ins_io_ack_i, .ins_par_ack_i,
    .ins_trap_on_i, .ins_ld_state_i, .ins_ld_reg_i, .ld_trap_bit_i,
    .ins_trap_ret_i, .stall_exp_i(stall_exp), .wdog_exp_i(wdog_exp),
    .set_o(set_vec), .clr_o(clr_vec)
  );

  for (genvar g = 0; g < NumFlags; g++) begin : g_flag
    sticky_flag u_ff (
      .clk_i, .rst_ni, .set_i(set_vec[g]), .clr_i(clr_vec[g]), .q_o(flag_q[g])
    );
  end

  assign demand_o     = flag_q[FL_DEMAND];
  assign overflow_o   = flag_q[FL_OVF];
  assign io_err_o     = flag_q[FL_IOERR];
  assign parity_err_o = flag_q[FL_PARITY];
  assign trap_mode_o  = flag_q[FL_TRAP];
  assign test_o       = flag_q[FL_TEST];
  assign stall_o      = flag_q[FL_STALL];
  assign irq_stall_o  = flag_q[FL_IRQSTALL];
endmodule

// File: rtl/console_flags_chk.sv
module console_flags_chk (
  input logic clk_i, rst_ni, init_i, console_en_i, dmd_release_i, alarm_clr_i,
  input logic stall_en_sw_i, ovf_evt_i, io_err_evt_i, par_err_evt_i,
  input logic ins_dmd_ack_i, ins_ovf_ack_i, ins_io_ack_i, ins_par_ack_i,
  input logic ins_trap_on_i, ins_ld_reg_i, ins_trap_ret_i,
  input logic demand_o, overflow_o, io_err_o, parity_err_o, trap_mode_o,
  input logic test_o, stall_o, irq_stall_o
);
  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |->
    !(demand_o | overflow_o | io_err_o | parity_err_o | trap_mode_o | test_o | stall_o | irq_stall_o));
  p_demand_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmd_release_i |=> demand_o);
  p_demand_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_dmd_ack_i && !dmd_release_i) |=> !demand_o);
  p_ovf_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ins_ovf_ack_i || ins_ld_reg_i || init_i) && !ovf_evt_i) |=> !overflow_o);
  p_ioerr_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_err_evt_i |=> io_err_o);
  p_alarm_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_clr_i && !console_en_i && io_err_o && !ins_io_ack_i && !init_i) |=> io_err_o);
  p_trap_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_trap_on_i |=> trap_mode_o);
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_evt_i && ins_par_ack_i) |=> parity_err_o);
  p_stall_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !init_i) |=> stall_o);
  p_stall_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && console_en_i && !stall_en_sw_i) |=> !stall_o);
  p_wdog_clr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_trap_ret_i |=> !irq_stall_o);
endmodule

bind console_flags console_flags_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .console_en_i(console_en_i),
  .dmd_release_i(dmd_release_i), .alarm_clr_i(alarm_clr_i),
  .stall_en_sw_i(stall_en_sw_i), .ovf_evt_i(ovf_evt_i), .io_err_evt_i(io_err_evt_i),
  .par_err_evt_i(par_err_evt_i), .ins_dmd_ack_i(ins_dmd_ack_i),
  .ins_ovf_ack_i(ins_ovf_ack_i), .ins_io_ack_i(ins_io_ack_i),
  .ins_par_ack_i(ins_par_ack_i), .ins_trap_on_i(ins_trap_on_i),
  .ins_ld_reg_i(ins_ld_reg_i), .ins_trap_ret_i(ins_trap_ret_i),
  .demand_o(demand_o), .overflow_o(overflow_o), .io_err_o(io_err_o),
  .parity_err_o(parity_err_o), .trap_mode_o(trap_mode_o), .test_o(test_o),
  .stall_o(stall_o), .irq_stall_o(irq_stall_o)
);

// File: tb/console_flags_tb.sv
module console_flags_tb;
  localparam int STALL = 20;
  localparam int WDOG  = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic init_i = 0, console_en_i = 1, dmd_release_i = 0, alarm_clr_i = 0;
  logic stall_en_sw_i = 0, irq_lock_sw_i = 1, mprot_lock_sw_i = 0;
  logic ovf_evt_i = 0, io_err_evt_i = 0, par_err_evt_i = 0, trap_err_i = 0;
  logic test_set_i = 0, test_clr_i = 0, ins_dmd_ack_i = 0, ins_ovf_ack_i = 0;
  logic ins_io_ack_i = 0, ins_par_ack_i = 0, ins_trap_on_i = 0, ins_ld_state_i = 0;
  logic ins_ld_reg_i = 0, ld_trap_bit_i = 0, ins_stall_hold_i = 0, ins_trap_ret_i = 0;
  logic demand_o, overflow_o, io_err_o, parity_err_o, trap_mode_o, test_o, stall_o, irq_stall_o;

  always #5 clk_i = ~clk_i;

  console_flags #(.STALL_CYCLES(STALL), .WDOG_CYCLES(WDOG)) u_dut (.*);

  // bit order: irq_stall, stall, test, trap, parity, io, ovf, demand
  logic [7:0] act;
  assign act = {irq_stall_o, stall_o, test_o, trap_mode_o, parity_err_o, io_err_o, overflow_o, demand_o};

  typedef struct { logic [7:0] v; string r; } item_t;
  item_t sb_q[$];
  int checks = 0, errors = 0;
  logic [7:0] exp_f = '0;
  logic exp_stall = 0, exp_irq = 0;

  task automatic chk(input logic [7:0] a, input logic [7:0] e, input string r);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  // monitor: compare one expected item per cycle
  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(act, it.v, it.r);
    end
  end

  task automatic clear_strobes();
    init_i = 0; dmd_release_i = 0; alarm_clr_i = 0; ovf_evt_i = 0; io_err_evt_i = 0;
    par_err_evt_i = 0; trap_err_i = 0; test_set_i = 0; test_clr_i = 0; ins_dmd_ack_i = 0;
    ins_ovf_ack_i = 0; ins_io_ack_i = 0; ins_par_ack_i = 0; ins_trap_on_i = 0;
    ins_ld_state_i = 0; ins_ld_reg_i = 0; ld_trap_bit_i = 0; ins_stall_hold_i = 0;
    ins_trap_ret_i = 0;
  endtask

  // driver: inputs already set after a negedge; predict, clock, push expectation
  task automatic cyc(input string r);
    logic [7:0] n;
    logic cen_alarm;
    cen_alarm = alarm_clr_i & console_en_i;
    n[0] = dmd_release_i | (exp_f[0] & ~(ins_dmd_ack_i | init_i));
    n[1] = ovf_evt_i | (exp_f[1] & ~(ins_ovf_ack_i | ins_ld_reg_i | init_i));
    n[2] = io_err_evt_i | (exp_f[2] & ~(ins_io_ack_i | cen_alarm | init_i));
    n[3] = par_err_evt_i | (exp_f[3] & ~(ins_par_ack_i | cen_alarm | init_i));
    n[4] = ins_trap_on_i | ((ins_ld_state_i | ins_ld_reg_i) & ld_trap_bit_i)
         | (exp_f[4] & ~(trap_err_i | (mprot_lock_sw_i & console_en_i)));
    n[5] = test_set_i | (exp_f[5] & ~(test_clr_i | init_i));
    n[6] = exp_stall;
    n[7] = exp_irq;
    exp_f = n;
    @(posedge clk_i);
    #1;
    sb_q.push_back('{v: n, r: r});
    @(negedge clk_i);
    clear_strobes();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(act, 8'h00, "R1 reset state");
    rst_ni = 1;
    @(negedge clk_i);
    cyc("R1 idle after reset");

    // R2 demand
    dmd_release_i = 1; cyc("R2 demand set");
    cyc("R2 demand held");
    ins_dmd_ack_i = 1; cyc("R2 demand ack clear");
    dmd_release_i = 1; cyc("R2 demand set again");
    init_i = 1; cyc("R2 init clears demand");

    // R3 overflow
    ovf_evt_i = 1; cyc("R3 overflow set");
    ins_ovf_ack_i = 1; cyc("R3 overflow test clear");
    ovf_evt_i = 1; cyc("R3 overflow set");
    ins_ld_reg_i = 1; cyc("R3 load reg clears overflow");
    ovf_evt_i = 1; cyc("R3 overflow set");
    init_i = 1; cyc("R3 init clears overflow");

    // R4 R5 R6 error flags and alarm button
    io_err_evt_i = 1; par_err_evt_i = 1; cyc("R4 R5 error flags set");
    console_en_i = 0; alarm_clr_i = 1; cyc("R6 alarm clear ignored, console off");
    console_en_i = 1; cyc("R6 flags still held");
    alarm_clr_i = 1; cyc("R4 R5 alarm clear with console on");
    io_err_evt_i = 1; cyc("R4 io error set");
    ins_io_ack_i = 1; cyc("R4 io test clear");
    par_err_evt_i = 1; cyc("R5 parity set");
    ins_par_ack_i = 1; cyc("R5 parity test clear");
    io_err_evt_i = 1; par_err_evt_i = 1; cyc("R4 R5 set");
    init_i = 1; cyc("R4 R5 init clears");

    // R7 trap mode
    ins_trap_on_i = 1; cyc("R7 trap set by instruction");
    mprot_lock_sw_i = 1; cyc("R7 lockout clears trap");
    mprot_lock_sw_i = 0;
    ins_ld_state_i = 1; ld_trap_bit_i = 0; cyc("R7 load with bit 0 leaves trap clear");
    ins_ld_state_i = 1; ld_trap_bit_i = 1; cyc("R7 load state bit 1 sets trap");
    trap_err_i = 1; cyc("R7 trap error clears");
    ins_ld_reg_i = 1; ld_trap_bit_i = 1; cyc("R7 load reg bit 1 sets trap");
    init_i = 1; cyc("R7 init leaves trap");
    console_en_i = 0; mprot_lock_sw_i = 1; cyc("R7 lockout ignored with console off");
    console_en_i = 1; mprot_lock_sw_i = 0; trap_err_i = 1; cyc("R7 trap error clears");

    // R8 test flag
    test_set_i = 1; cyc("R8 test set");
    test_clr_i = 1; cyc("R8 test clear");
    test_set_i = 1; cyc("R8 test set");
    init_i = 1; cyc("R8 init clears test");

    // R9 set wins
    dmd_release_i = 1; ins_dmd_ack_i = 1; cyc("R9 demand set wins");
    io_err_evt_i = 1; ins_io_ack_i = 1; cyc("R9 io set wins");
    par_err_evt_i = 1; alarm_clr_i = 1; cyc("R9 parity set wins");
    ins_trap_on_i = 1; trap_err_i = 1; cyc("R9 trap set wins");
    test_set_i = 1; test_clr_i = 1; cyc("R9 test set wins");
    init_i = 1; trap_err_i = 1; cyc("R9 cleanup");

    // R10 stall timer
    stall_en_sw_i = 1; ins_stall_hold_i = 1; cyc("R10 stall restart");
    for (int k = 1; k <= 5; k++) cyc("R10 stall counting");
    ins_stall_hold_i = 1; cyc("R10 stall hold-off restarts");
    for (int k = 1; k <= STALL; k++) begin
      exp_stall = (k == STALL);
      cyc("R10 stall expiry edge");
    end
    ins_stall_hold_i = 1; cyc("R10 stall sticky over hold-off");
    cyc("R10 stall sticky");
    stall_en_sw_i = 0; init_i = 1; exp_stall = 0; cyc("R10 init clears stall");

    // R11 stall timer off
    ins_stall_hold_i = 1; cyc("R11 stall switch off");
    for (int k = 1; k <= 2 * STALL; k++) cyc("R11 no stall when off");
    console_en_i = 0; ins_stall_hold_i = 1; ins_trap_ret_i = 1; cyc("R11 console off forces timers");
    for (int k = 1; k <= STALL; k++) begin
      exp_irq = (k >= WDOG);
      exp_stall = (k >= STALL);
      cyc("R10 R12 timers run with console off");
    end
    console_en_i = 1; init_i = 1; exp_stall = 0; exp_irq = 0; cyc("R12 init clears both");

    // R12 interrupt watchdog
    irq_lock_sw_i = 0; ins_trap_ret_i = 1; cyc("R12 watchdog restart");
    for (int k = 1; k <= WDOG; k++) begin
      exp_irq = (k == WDOG);
      cyc("R12 watchdog expiry edge");
    end
    ins_trap_ret_i = 1; exp_irq = 0; cyc("R12 trap return clears");
    irq_lock_sw_i = 1; cyc("R12 lockout");
    for (int k = 1; k <= 2 * WDOG; k++) cyc("R12 no expiry in lockout");
    irq_lock_sw_i = 0; ins_trap_ret_i = 1; cyc("R12 restart");
    for (int k = 1; k <= WDOG; k++) begin
      exp_irq = (k == WDOG);
      cyc("R12 expiry again");
    end
    irq_lock_sw_i = 1; init_i = 1; exp_irq = 0; cyc("R12 init clears watchdog flag");

    repeat (3) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule